// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front End

This block sits on the device side of an asynchronous parallel NOR flash pin interface. A fast internal clock samples the active-low control pins (chip enable, output enable, write enable and the chip reset pin), the word address, a byte/word mode pin and the input half of the data bus. Each control pin passes through a two-flop synchronizer and a stability filter, so short spikes never reach the decoder. The filtered pins are decoded into reads, command writes, output disable and standby.

Reads are served from an eight-word page buffer. The buffer is loaded from a behavioural array model whenever the requested page differs from the buffered one. A read inside the buffered page is answered almost at once, and a page change pays a parameterised load latency. In byte mode, the top data pin serves as the least significant byte address. Writes never touch the array. The address and data are captured by the edge rules of the bus and handed to a command-interface capture port as a one-cycle pulse. A write made while output enable is low is dropped, and a sticky error flag is raised.

Top module: `nor_bus_front`

## Requirements
- R1: After the system reset is released, `dq_oe`, `cmd_valid` and `proto_err` are all 0.
- R2: In word mode (`byte_n` high), with chip enable and output enable low and write enable high, `dq_oe` is 1 and `dq_out` equals the array word at address `w`, which is `(w*37 + 16'h1200) mod 65536`.
- R3: In byte mode (`byte_n` low), `dq_in[15]` is the byte address LSB. A value of 0 returns bits 7:0 of the addressed word and 1 returns bits 15:8, on `dq_out[7:0]`, with `dq_out[15:8]` = 0.
- R4: While output enable is high, `dq_oe` is 0.
- R5: While chip enable is high (standby), `dq_oe` is 0.
- R6: When the address moves to another word of the buffered page (same address bits above bit 2), valid data appears within 2 cycles. When it moves to another page, valid data appears no sooner than MISS_LAT cycles and no later than MISS_LAT+3 cycles.
- R7: Each write produces exactly one `cmd_valid` pulse of one cycle. `cmd_addr` is the address present when the later of chip enable and write enable fell. `cmd_data` is `dq_in` when the earlier of the two rose.
- R8: A low pulse shorter than FILT_CYC clocks on chip enable, write enable or the reset pin has no effect: no command, no read and no reset.
- R9: A write during which output enable is low produces no `cmd_valid`. It sets `proto_err`, which stays set until a chip reset.
- R10: Holding the reset pin low for FILT_CYC clocks or more clears `proto_err` and stops read drive. Once it is released, reads return correct data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| rp_n | input | 1 | Chip reset pin, active low |
| byte_n | input | 1 | Low selects byte mode, high selects word mode |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data bus input half; bit 15 is the byte address LSB in byte mode |
| dq_out | output | 16 | Data bus output half |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| cmd_valid | output | 1 | One-cycle pulse for a captured command write |
| cmd_addr | output | AW | Captured command address |
| cmd_data | output | 16 | Captured command data |
| proto_err | output | 1 | Sticky flag for a write made with output enable low |

## Verification
The read path is swept over every word address in word mode, and over a block of addresses with both byte-select values in byte mode. This separates the word/byte selection and the in-page indexing from the page tag compare. Page-hit and page-miss address steps are timed against each other to show that the buffer reuses its contents instead of reloading on every step. Writes are run with both orders of strobe fall and strobe rise, with the address and data changed between the edges, so that a capture on the wrong edge yields a wrong value. Two-cycle spikes on write enable and the reset pin, and a write with output enable low, check the filter and the error path.

// File: rtl/nor_bus_pkg.sv
package nor_bus_pkg;

  typedef enum logic {RD_IDLE, RD_LOAD} rd_state_e;

  // Behavioural array content: a fixed arithmetic pattern per word address.
  function automatic logic [15:0] array_word(input logic [15:0] w);
    return 16'(w * 16'd37 + 16'h1200);
  endfunction

endpackage

// File: rtl/nor_pin_filter.sv
module nor_pin_filter #(
  parameter int  FILT_CYC = 3,
  parameter bit  RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          s1_q, s2_q, filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (s2_q == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      filt_d = s2_q;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= RST_VAL;
      s2_q   <= RST_VAL;
      filt_q <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sync_o = s2_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/nor_page_reader.sv
module nor_page_reader
  import nor_bus_pkg::*;
#(
  parameter int AW       = 8,
  parameter int MISS_LAT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  logic          clr,
  input  logic [AW-1:0] addr_q,
  input  logic          byte_mode,
  input  logic          byte_sel,
  output logic [15:0]   dq_out,
  output logic          dq_oe
);
  localparam int PAGE_W = 3;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int TAG_W  = AW - PAGE_W;
  localparam int CW     = $clog2(MISS_LAT + 1);

  rd_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [TAG_W-1:0] tag_q, tag_d, ld_tag_q, ld_tag_d;
  logic           valid_q, valid_d, fill;
  logic [15:0]    pbuf_q [PAGE_N];
  logic           hit;
  logic [15:0]    word;

  assign hit = valid_q && (tag_q == addr_q[AW-1:PAGE_W]);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    tag_d    = tag_q;
    ld_tag_d = ld_tag_q;
    valid_d  = valid_q;
    fill     = 1'b0;
    case (state_q)
      RD_IDLE: if (rd_act && !hit) begin
        state_d  = RD_LOAD;
        cnt_d    = CW'(MISS_LAT - 1);
        ld_tag_d = addr_q[AW-1:PAGE_W];
      end
      RD_LOAD: if (cnt_q == '0) begin
        state_d = RD_IDLE;
        fill    = 1'b1;
        tag_d   = ld_tag_q;
        valid_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      default: state_d = RD_IDLE;
    endcase
    if (clr) begin
      state_d = RD_IDLE;
      valid_d = 1'b0;
      fill    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RD_IDLE;
      cnt_q    <= '0;
      tag_q    <= '0;
      ld_tag_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      tag_q    <= tag_d;
      ld_tag_q <= ld_tag_d;
      valid_q  <= valid_d;
    end
  end

  // Page storage: data path only, loaded under the fill enable.
  for (genvar i = 0; i < PAGE_N; i++) begin : g_page
    always_ff @(posedge clk) begin
      if (fill) pbuf_q[i] <= array_word(16'({ld_tag_q, PAGE_W'(i)}));
    end
  end

  assign word   = pbuf_q[addr_q[PAGE_W-1:0]];
  assign dq_out = byte_mode ? {8'h00, (byte_sel ? word[15:8] : word[7:0])} : word;
  assign dq_oe  = rd_act && hit;
endmodule

// File: rtl/nor_write_capture.sv
module nor_write_capture #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ce_f,
  input  logic          we_f,
  input  logic          oe_f,
  input  logic [AW-1:0] addr_q,
  input  logic [15:0]   dq_q,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [15:0]   cmd_data,
  output logic          proto_err
);
  logic          strobe, strobe_q;
  logic          bad_q, bad_d, err_q, err_d, vld_d, vld_q;
  logic [AW-1:0] addr_lq, addr_ld;
  logic [15:0]   data_q, data_d;

  assign strobe = !ce_f && !we_f;

  always_comb begin
    bad_d   = bad_q;
    err_d   = err_q;
    vld_d   = 1'b0;
    addr_ld = addr_lq;
    data_d  = data_q;
    if (strobe && !strobe_q) begin        // later falling edge
      addr_ld = addr_q;
      bad_d   = !oe_f;
    end else if (strobe && !oe_f) begin
      bad_d = 1'b1;
    end
    if (!strobe && strobe_q) begin        // earlier rising edge
      if (bad_q) begin
        err_d = 1'b1;
      end else begin
        vld_d  = 1'b1;
        data_d = dq_q;
      end
      bad_d = 1'b0;
    end
    if (clr) begin
      bad_d = 1'b0;
      err_d = 1'b0;
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      bad_q    <= 1'b0;
      err_q    <= 1'b0;
      vld_q    <= 1'b0;
      addr_lq  <= '0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe && !clr;
      bad_q    <= bad_d;
      err_q    <= err_d;
      vld_q    <= vld_d;
      addr_lq  <= addr_ld;
      data_q   <= data_d;
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_addr  = addr_lq;
  assign cmd_data  = data_q;
  assign proto_err = err_q;
endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front #(
  parameter int AW       = 8,
  parameter int FILT_CYC = 3,
  parameter int MISS_LAT = 6
) (
  input  logic          clk,
  input  logic          sys_rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          rp_n,
  input  logic          byte_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [15:0]   cmd_data,
  output logic          proto_err
);
  localparam int NPIN = 4;  // 0: ce, 1: oe, 2: we, 3: rp

  logic            rst_m_q, rst_q_n;
  logic [NPIN-1:0] pin_raw, pin_sync, pin_filt;
  logic            ce_f, oe_f, we_f, rp_f, ce_s, we_s;
  logic [AW-1:0]   addr_q;
  logic [15:0]     dq_q;
  logic            byte_q, rd_act, clr;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rst_m_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_q_n <= rst_m_q;
    end
  end

  assign pin_raw = {rp_n, we_n, oe_n, ce_n};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    nor_pin_filter #(
      .FILT_CYC (FILT_CYC),
      .RST_VAL  ((i == 3) ? 1'b0 : 1'b1)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .pin_i  (pin_raw[i]),
      .sync_o (pin_sync[i]),
      .filt_o (pin_filt[i])
    );
  end

  assign ce_f = pin_filt[0];
  assign oe_f = pin_filt[1];
  assign we_f = pin_filt[2];
  assign rp_f = pin_filt[3];
  assign ce_s = pin_sync[0];
  assign we_s = pin_sync[2];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q <= '0;
      dq_q   <= '0;
      byte_q <= 1'b1;
    end else begin
      addr_q <= addr;
      dq_q   <= dq_in;
      byte_q <= byte_n;
    end
  end

  assign clr    = !rp_f;
  assign rd_act = !ce_f && !oe_f && we_f && rp_f;

  nor_page_reader #(.AW(AW), .MISS_LAT(MISS_LAT)) u_rd (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .rd_act    (rd_act),
    .clr       (clr),
    .addr_q    (addr_q),
    .byte_mode (!byte_q),
    .byte_sel  (dq_q[15]),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  nor_write_capture #(.AW(AW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clr       (clr),
    .ce_f      (ce_f),
    .we_f      (we_f),
    .oe_f      (oe_f),
    .addr_q    (addr_q),
    .dq_q      (dq_q),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .proto_err (proto_err)
  );
endmodule

// File: rtl/nor_bus_front_chk.sv
module nor_bus_front_chk (
  input logic clk,
  input logic rst_q_n,
  input logic ce_f,
  input logic ce_s,
  input logic we_f,
  input logic we_s,
  input logic oe_f,
  input logic rp_f,
  input logic dq_oe,
  input logic cmd_valid,
  input logic proto_err
);
  // R4: no drive while output enable is high
  p_hiz_oe_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    oe_f |-> !dq_oe);

  // R5: standby keeps the bus released
  p_hiz_standby_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ce_f |-> !dq_oe);

  // R7: a command is a single-cycle pulse
  p_cmd_single_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    cmd_valid |=> !cmd_valid);

  // R8: filtered chip enable changes only after the synchronized level held
  p_ce_filter_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $changed(ce_f) |-> ($past(ce_s) == ce_f && $past(ce_s, 2) == ce_f));

  // R8: same for write enable
  p_we_filter_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $changed(we_f) |-> ($past(we_s) == we_f && $past(we_s, 2) == we_f));

  // R9: error flag holds until chip reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (proto_err && rp_f) |=> proto_err);

  // R10: chip reset clears the flag and suppresses commands
  p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rp_f |=> (!proto_err && !cmd_valid));
endmodule

bind nor_bus_front nor_bus_front_chk chk_i (.*);

// File: tb/nor_bus_front_tb_top.sv
module nor_bus_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 8;
  localparam int FILT_CYC   = 3;
  localparam int MISS_LAT   = 6;

  logic          clk = 1'b0;
  logic          sys_rst_n, ce_n, oe_n, we_n, rp_n, byte_n;
  logic [AW-1:0] addr;
  logic [15:0]   dq_in, dq_out, cmd_data;
  logic          dq_oe, cmd_valid, proto_err;
  logic [AW-1:0] cmd_addr;

  int checks = 0, failures = 0, cmd_cnt = 0;
  logic [AW-1:0] last_addr;
  logic [15:0]   last_data;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_bus_front #(.AW(AW), .FILT_CYC(FILT_CYC), .MISS_LAT(MISS_LAT)) dut_i (
    .clk(clk), .sys_rst_n(sys_rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rp_n(rp_n), .byte_n(byte_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .proto_err(proto_err)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      cmd_cnt++;
      last_addr = cmd_addr;
      last_data = cmd_data;
    end
  end

  function automatic logic [15:0] exp_word(input int w);
    return 16'(w * 37 + 'h1200);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lat(input logic [AW-1:0] a, input logic [15:0] e, output int n);
    addr = a;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(dq_oe && dq_out == e) && n < 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, c0;
    sys_rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; rp_n = 1; byte_n = 1;
    addr = '0; dq_in = '0;
    cyc(5);
    sys_rst_n = 1;
    cyc(3);
    // R1 reset state
    chk(!dq_oe, "R1 dq_oe", dq_oe, 0);
    chk(!cmd_valid, "R1 cmd_valid", cmd_valid, 0);
    chk(!proto_err, "R1 proto_err", proto_err, 0);
    cyc(12);

    // R2 word-mode sweep over all addresses
    ce_n = 0; oe_n = 0;
    for (int a = 0; a < (1 << AW); a++) begin
      addr = AW'(a);
      cyc(14);
      chk(dq_oe && dq_out == exp_word(a), "R2 word read", {dq_oe, dq_out}, {1'b1, exp_word(a)});
    end

    // R6 hit then miss latency
    addr = 8'h40; cyc(16);
    lat(8'h45, exp_word('h45), n);
    chk(n <= 2, "R6 page hit latency", n, 2);
    lat(8'h80, exp_word('h80), n);
    chk(n >= MISS_LAT && n <= MISS_LAT + 3, "R6 page miss latency", n, MISS_LAT);

    // R3 byte-mode sweep
    byte_n = 0;
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 2; b++) begin
        logic [15:0] w, e;
        w = exp_word(a);
        e = {8'h00, (b != 0) ? w[15:8] : w[7:0]};
        addr = AW'(a); dq_in = {b[0], 15'h0};
        cyc(14);
        chk(dq_oe && dq_out == e, "R3 byte read", {dq_oe, dq_out}, {1'b1, e});
      end
    end
    byte_n = 1; dq_in = '0;

    // R4 output disable
    oe_n = 1; cyc(10);
    chk(!dq_oe, "R4 oe high", dq_oe, 0);
    oe_n = 0; cyc(14);
    chk(dq_oe, "R4 oe low again", dq_oe, 1);
    // R5 standby
    ce_n = 1; cyc(10);
    chk(!dq_oe, "R5 standby", dq_oe, 0);
    oe_n = 1; cyc(10);

    // R7 write enable falls first, chip enable rises first
    c0 = cmd_cnt;
    addr = 8'h11; dq_in = 16'h0F0F; we_n = 0; cyc(10);
    addr = 8'h22; ce_n = 0; cyc(10);
    addr = 8'h33; dq_in = 16'hBEEF; cyc(10);
    ce_n = 1; cyc(10);
    dq_in = 16'hDEAD; we_n = 1; cyc(10);
    chk(cmd_cnt == c0 + 1, "R7 pulse count A", cmd_cnt - c0, 1);
    chk(last_addr == 8'h22, "R7 addr at later fall A", last_addr, 'h22);
    chk(last_data == 16'hBEEF, "R7 data at earlier rise A", last_data, 'hBEEF);

    // R7 chip enable falls first, write enable rises first
    c0 = cmd_cnt;
    addr = 8'h44; ce_n = 0; cyc(10);
    addr = 8'h55; we_n = 0; cyc(10);
    addr = 8'h66; dq_in = 16'h1357; cyc(10);
    we_n = 1; cyc(10);
    dq_in = 16'h2468; ce_n = 1; cyc(10);
    chk(cmd_cnt == c0 + 1, "R7 pulse count B", cmd_cnt - c0, 1);
    chk(last_addr == 8'h55, "R7 addr at later fall B", last_addr, 'h55);
    chk(last_data == 16'h1357, "R7 data at earlier rise B", last_data, 'h1357);

    // R8 two-cycle spike on write enable
    c0 = cmd_cnt;
    ce_n = 0; cyc(10);
    we_n = 0; cyc(FILT_CYC - 1); we_n = 1; cyc(12);
    ce_n = 1; cyc(10);
    chk(cmd_cnt == c0, "R8 we spike ignored", cmd_cnt - c0, 0);
    // R8 spike on chip enable during read setup: no drive
    oe_n = 0;
    begin
      bit seen = 0;
      ce_n = 0;
      for (int k = 0; k < FILT_CYC - 1; k++) begin @(negedge clk); seen |= dq_oe; end
      ce_n = 1;
      for (int k = 0; k < 12; k++) begin @(negedge clk); seen |= dq_oe; end
      chk(!seen, "R8 ce spike ignored", seen, 0);
    end

    // R9 write with output enable low
    c0 = cmd_cnt;
    ce_n = 0; cyc(14);
    we_n = 0; cyc(10); we_n = 1; cyc(10);
    oe_n = 1; ce_n = 1; cyc(10);
    chk(cmd_cnt == c0, "R9 write discarded", cmd_cnt - c0, 0);
    chk(proto_err, "R9 error set", proto_err, 1);
    cyc(20);
    chk(proto_err, "R9 error sticky", proto_err, 1);

    // R8 reset-pin spike keeps the flag
    rp_n = 0; cyc(FILT_CYC - 1); rp_n = 1; cyc(12);
    chk(proto_err, "R8 rp spike ignored", proto_err, 1);

    // R10 chip reset
    ce_n = 0; oe_n = 0; addr = 8'h9A; cyc(14);
    rp_n = 0; cyc(10);
    chk(!proto_err, "R10 error cleared", proto_err, 0);
    chk(!dq_oe, "R10 no drive in reset", dq_oe, 0);
    rp_n = 1; cyc(20);
    chk(dq_oe && dq_out == exp_word('h9A), "R10 read after reset", {dq_oe, dq_out}, {1'b1, exp_word('h9A)});

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule